// File: doc/BRIEF.md
# Internal Data Space Address Router

This block sits between an 8-bit processor core and its 256-byte internal data store. For each access it takes an operation kind, an operand byte and write data. It works out which physical byte the access refers to: a register of the active bank, a directly addressed byte, a byte pointed to by a bank register, a single bit in the bit-addressable RAM window or in a bit-addressable special register, or a stack slot.

The upper half of the address range is shared. A direct access at 0x80 or above leaves the block on the special-register port. An indirect access at the same address reaches a separate upper RAM half. Reads are combinational: the byte appears in the cycle the access is presented. Writes commit at the next rising clock edge. A bit write merges the new bit into the containing byte inside that one access. The stack unit keeps its own pointer. A push writes to the slot after the pointer, and a pop reads the slot at the pointer.

Top module: `idata_router`

## Requirements
- R1: After reset every RAM byte reads 0x00 and the stack pointer holds 0x07, so the first push lands at byte 0x08.
- R2: Operation code 3 (register) addresses byte `bank*8 + operand[2:0]`, where `bank` is the 2-bit bank select (bit 1 is the high bank bit).
- R3: Operation code 0 (direct) reaches RAM for operands below 0x80. For operands 0x80 and above it raises `sfrReq` with `sfrAddr` equal to the operand, returns `sfrRdata` as read data, and leaves RAM unchanged.
- R4: Operation code 1 (indirect) uses as pointer the byte in register 0 (operand bit 0 = 0) or register 1 (operand bit 0 = 1) of the active bank. Pointers of 0x80 and above reach the upper RAM half and never raise `sfrReq`.
- R5: Operation code 2 (bit) with a bit address b below 0x80 selects bit b[2:0] of RAM byte 0x20 + b[6:3]; `rdBit` returns that bit.
- R6: Operation code 2 with b of 0x80 or above selects bit b[2:0] of the special register at b with its low three bits cleared, on the special-register port.
- R7: A bit write sets the selected bit to `accWdata[0]` and leaves the other seven bits of the byte unchanged, within one access cycle.
- R8: Operation code 4 (push) increments the stack pointer and writes `accWdata` to the new pointer location.
- R9: Operation code 5 (pop) returns the byte at the stack pointer, then decrements the pointer. The pointer wraps modulo 256 both ways.
- R10: `sfrReq` is high only during a valid special-register access, and `sfrWrite` only when that access writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | Access present this cycle |
| accOp | input | 3 | 0 direct, 1 indirect, 2 bit, 3 register, 4 push, 5 pop |
| accBank | input | 2 | Active register bank |
| accWrite | input | 1 | Write for direct, indirect, bit and register operations |
| accOperand | input | 8 | Address, bit address, register index or pointer select |
| accWdata | input | 8 | Write data (bit writes use bit 0) |
| rdData | output | 8 | Byte addressed by the access |
| rdBit | output | 1 | Selected bit for bit operations |
| sfrReq | output | 1 | Special-register access request |
| sfrWrite | output | 1 | Special-register write strobe |
| sfrAddr | output | 8 | Special-register address |
| sfrWdata | output | 8 | Byte written to the special register |
| sfrRdata | input | 8 | Special-register read data |

## Verification
A wrong bank decode or bit-address remap shows up as a read that returns another byte's value on the first read after the write. A stale or wrongly wrapped stack pointer changes which slot a pop returns; this appears at the first pop after the fault, and when it shifts a push target it also shows through a later register read of the overwritten slot. Routing a direct upper access to RAM instead of to the special-register port shows at once as a missing `sfrReq`. It also shows one access later as an indirect read at the same address returning data it should never have received.

// File: rtl/idata_pkg.sv
package idata_pkg;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;
  localparam int BITW = $clog2(DW);
  localparam logic [AW-1:0] SP_INIT = 8'h07;
  localparam logic [AW-1:0] BIT_BASE = 8'h20;

  typedef enum logic [2:0] {
    OP_DIRECT   = 3'd0,
    OP_INDIRECT = 3'd1,
    OP_BIT      = 3'd2,
    OP_REG      = 3'd3,
    OP_PUSH     = 3'd4,
    OP_POP      = 3'd5
  } accOp_e;

  typedef struct packed {
    logic [AW-1:0]   addr;
    logic            toSfr;
    logic            wrEn;
    logic            bitOp;
    logic [BITW-1:0] bitPos;
    logic            spInc;
    logic            spDec;
  } strobe_t;
endpackage

// File: rtl/idata_ctrl.sv
module idata_ctrl
  import idata_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          accValid,
  input  logic [2:0]    accOp,
  input  logic [1:0]    accBank,
  input  logic          accWrite,
  input  logic [AW-1:0] accOperand,
  input  logic [AW-1:0] ptrVal,
  input  logic [AW-1:0] spVal,
  output strobe_t       strb
);
  always_comb begin
    strb = '0;
    if (accValid) begin
      case (accOp_e'(accOp))
        OP_DIRECT: begin
          strb.addr  = accOperand;
          strb.toSfr = accOperand[AW-1];
          strb.wrEn  = accWrite;
        end
        OP_INDIRECT: begin
          strb.addr = ptrVal;
          strb.wrEn = accWrite;
        end
        OP_BIT: begin
          strb.bitOp  = 1'b1;
          strb.bitPos = accOperand[BITW-1:0];
          strb.wrEn   = accWrite;
          if (accOperand[AW-1]) begin
            strb.addr  = {accOperand[AW-1:BITW], {BITW{1'b0}}};
            strb.toSfr = 1'b1;
          end else begin
            strb.addr = BIT_BASE + AW'(accOperand[AW-2:BITW]);
          end
        end
        OP_REG: begin
          strb.addr = {3'b000, accBank, accOperand[2:0]};
          strb.wrEn = accWrite;
        end
        OP_PUSH: begin
          strb.addr  = spVal + 1'b1;
          strb.wrEn  = 1'b1;
          strb.spInc = 1'b1;
        end
        OP_POP: begin
          strb.addr  = spVal;
          strb.spDec = 1'b1;
        end
        default: strb = '0;
      endcase
    end
  end

  AST_SFR_UPPER: assert property (@(posedge clk) disable iff (!rstN)
    strb.toSfr |-> strb.addr[AW-1]); // R3
  AST_SFR_BIT_ALIGN: assert property (@(posedge clk) disable iff (!rstN)
    (strb.toSfr && strb.bitOp) |-> (strb.addr[BITW-1:0] == '0)); // R6
  AST_BIT_AREA: assert property (@(posedge clk) disable iff (!rstN)
    (strb.bitOp && !strb.toSfr) |-> (strb.addr[AW-1:4] == 4'h2)); // R5
  AST_REG_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accOp == OP_REG) |-> (strb.addr < 8'h20 && !strb.toSfr)); // R2
  AST_INDIRECT_RAM: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accOp == OP_INDIRECT) |-> !strb.toSfr); // R4
  AST_STACK_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.spInc && strb.spDec)); // R8
endmodule

// File: rtl/idata_path.sv
module idata_path
  import idata_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       strb,
  input  logic [1:0]    accBank,
  input  logic          ptrSel,
  input  logic [DW-1:0] accWdata,
  input  logic [DW-1:0] sfrRdata,
  output logic [AW-1:0] ptrVal,
  output logic [AW-1:0] spVal,
  output logic [DW-1:0] rdData,
  output logic          rdBit,
  output logic          sfrReq,
  output logic          sfrWrite,
  output logic [AW-1:0] sfrAddr,
  output logic [DW-1:0] sfrWdata
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] spQ;
  logic [DW-1:0] byteRd;
  logic [DW-1:0] wrByte;

  assign ptrVal = mem[{3'b000, accBank, 2'b00, ptrSel}];
  assign byteRd = strb.toSfr ? sfrRdata : mem[strb.addr];
  assign rdData = byteRd;
  assign rdBit  = byteRd[strb.bitPos];
  assign spVal  = spQ;

  for (genvar i = 0; i < DW; i++) begin : g_merge
    always_comb begin
      if (!strb.bitOp)               wrByte[i] = accWdata[i];
      else if (strb.bitPos == BITW'(i)) wrByte[i] = accWdata[0];
      else                           wrByte[i] = byteRd[i];
    end
  end

  assign sfrReq   = strb.toSfr;
  assign sfrWrite = strb.toSfr & strb.wrEn;
  assign sfrAddr  = strb.addr;
  assign sfrWdata = wrByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (strb.wrEn && !strb.toSfr) begin
      mem[strb.addr] <= wrByte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            spQ <= SP_INIT;
    else if (strb.spInc)  spQ <= spQ + 1'b1;
    else if (strb.spDec)  spQ <= spQ - 1'b1;
  end

  AST_SFR_KEEPS_RAM: assert property (@(posedge clk) disable iff (!rstN)
    strb.toSfr |=> (mem[$past(strb.addr)] == $past(mem[strb.addr]))); // R3
  AST_PUSH_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    strb.spInc |=> (mem[spQ] == $past(accWdata))); // R8
  AST_POP_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strb.spDec |=> (spQ == $past(spQ) - 8'd1)); // R9
endmodule

// File: rtl/idata_router.sv
module idata_router
  import idata_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          accValid,
  input  logic [2:0]    accOp,
  input  logic [1:0]    accBank,
  input  logic          accWrite,
  input  logic [7:0]    accOperand,
  input  logic [7:0]    accWdata,
  output logic [7:0]    rdData,
  output logic          rdBit,
  output logic          sfrReq,
  output logic          sfrWrite,
  output logic [7:0]    sfrAddr,
  output logic [7:0]    sfrWdata,
  input  logic [7:0]    sfrRdata
);
  strobe_t       strb;
  logic [AW-1:0] ptrVal;
  logic [AW-1:0] spVal;

  idata_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accOp(accOp),
    .accBank(accBank), .accWrite(accWrite), .accOperand(accOperand),
    .ptrVal(ptrVal), .spVal(spVal), .strb(strb)
  );

  idata_path i_path (
    .clk(clk), .rstN(rstN), .strb(strb), .accBank(accBank),
    .ptrSel(accOperand[0]), .accWdata(accWdata), .sfrRdata(sfrRdata),
    .ptrVal(ptrVal), .spVal(spVal), .rdData(rdData), .rdBit(rdBit),
    .sfrReq(sfrReq), .sfrWrite(sfrWrite), .sfrAddr(sfrAddr),
    .sfrWdata(sfrWdata)
  );

  AST_SFR_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |-> (!sfrReq && !sfrWrite)); // R10
  AST_SFR_WRITE_REQ: assert property (@(posedge clk) disable iff (!rstN)
    sfrWrite |-> sfrReq); // R10
endmodule

// File: tb/test_idata_router.sv
`timescale 1ns/1ps
module test_idata_router;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       accValid = 1'b0;
  logic [2:0] accOp = '0;
  logic [1:0] accBank = '0;
  logic       accWrite = 1'b0;
  logic [7:0] accOperand = '0;
  logic [7:0] accWdata = '0;
  logic [7:0] rdData, sfrAddr, sfrWdata, sfrRdata;
  logic       rdBit, sfrReq, sfrWrite;
  logic [7:0] sfrMem [128];
  int applied = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  idata_router i_idata_router (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accOp(accOp),
    .accBank(accBank), .accWrite(accWrite), .accOperand(accOperand),
    .accWdata(accWdata), .rdData(rdData), .rdBit(rdBit), .sfrReq(sfrReq),
    .sfrWrite(sfrWrite), .sfrAddr(sfrAddr), .sfrWdata(sfrWdata),
    .sfrRdata(sfrRdata)
  );

  assign sfrRdata = sfrMem[sfrAddr[6:0]];
  always @(posedge clk) begin
    if (!rstN) for (int i = 0; i < 128; i++) sfrMem[i] <= '0;
    else if (sfrWrite) sfrMem[sfrAddr[6:0]] <= sfrWdata;
  end

  // {req[3:0], op[2:0], bank[1:0], wr, operand[7:0], wdata[7:0], exp[7:0]}
  localparam int NV = 25;
  localparam logic [33:0] VEC [NV] = '{
    {4'd0, 3'd3, 2'd0, 1'b1, 8'h00, 8'h30, 8'h00},
    {4'd0, 3'd3, 2'd0, 1'b1, 8'h01, 8'h90, 8'h00},
    {4'd0, 3'd3, 2'd2, 1'b1, 8'h03, 8'h5A, 8'h00},
    {4'd2, 3'd0, 2'd0, 1'b0, 8'h13, 8'h00, 8'h5A}, // R2 bank 2 reg 3
    {4'd2, 3'd3, 2'd0, 1'b0, 8'h00, 8'h00, 8'h30}, // R2
    {4'd0, 3'd1, 2'd0, 1'b1, 8'h00, 8'hC3, 8'h00},
    {4'd4, 3'd0, 2'd0, 1'b0, 8'h30, 8'h00, 8'hC3}, // R4 via R0
    {4'd0, 3'd1, 2'd0, 1'b1, 8'h01, 8'h77, 8'h00},
    {4'd4, 3'd1, 2'd0, 1'b0, 8'h01, 8'h00, 8'h77}, // R4 upper RAM
    {4'd0, 3'd0, 2'd0, 1'b1, 8'h90, 8'hEE, 8'h00},
    {4'd3, 3'd1, 2'd0, 1'b0, 8'h01, 8'h00, 8'h77}, // R3 RAM untouched
    {4'd3, 3'd0, 2'd0, 1'b0, 8'h90, 8'h00, 8'hEE}, // R3 SFR read
    {4'd0, 3'd2, 2'd0, 1'b1, 8'h13, 8'h01, 8'h00},
    {4'd5, 3'd0, 2'd0, 1'b0, 8'h22, 8'h00, 8'h08}, // R5 bit 0x13
    {4'd0, 3'd0, 2'd0, 1'b1, 8'h22, 8'hF0, 8'h00},
    {4'd0, 3'd2, 2'd0, 1'b1, 8'h14, 8'h00, 8'h00},
    {4'd7, 3'd0, 2'd0, 1'b0, 8'h22, 8'h00, 8'hE0}, // R7 merge
    {4'd0, 3'd2, 2'd0, 1'b1, 8'h90, 8'h01, 8'h00},
    {4'd6, 3'd0, 2'd0, 1'b0, 8'h90, 8'h00, 8'hEF}, // R6
    {4'd5, 3'd2, 2'd0, 1'b0, 8'h7F, 8'h00, 8'h00}, // R5 top bit
    {4'd0, 3'd4, 2'd0, 1'b1, 8'h00, 8'hA1, 8'h00},
    {4'd0, 3'd4, 2'd0, 1'b1, 8'h00, 8'hA2, 8'h00},
    {4'd8, 3'd3, 2'd1, 1'b0, 8'h00, 8'h00, 8'hA1}, // R8 first push at 0x08
    {4'd9, 3'd5, 2'd0, 1'b0, 8'h00, 8'h00, 8'hA2}, // R9
    {4'd9, 3'd5, 2'd0, 1'b0, 8'h00, 8'h00, 8'hA1}  // R9
  };

  function automatic string tagOf(input logic [3:0] n);
    case (n)
      4'd1: return "R1";  4'd2: return "R2";  4'd3: return "R3";
      4'd4: return "R4";  4'd5: return "R5";  4'd6: return "R6";
      4'd7: return "R7";  4'd8: return "R8";  4'd9: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    applied++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] op, input logic [1:0] bank, input logic wr,
                       input logic [7:0] opnd, input logic [7:0] wd);
    @(negedge clk);
    accValid = 1'b1; accOp = op; accBank = bank; accWrite = wr;
    accOperand = opnd; accWdata = wd;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    accValid = 1'b0; accWrite = 1'b0;
    #1;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; accValid = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
    $finish;
  end

  initial begin
    doReset();
    idle();
    check("R10 idle sfrReq", {7'd0, sfrReq}, 8'h00);
    drive(3'd0, 2'd0, 1'b0, 8'h45, 8'h00);
    check("R1 ram cleared", rdData, 8'h00);

    for (int v = 0; v < NV; v++) begin
      drive(VEC[v][29:27], VEC[v][26:25], VEC[v][24], VEC[v][23:16], VEC[v][15:8]);
      if (VEC[v][33:30] != 4'd0) check(tagOf(VEC[v][33:30]), rdData, VEC[v][7:0]);
    end

    drive(3'd0, 2'd0, 1'b0, 8'h90, 8'h00);
    check("R3 sfrReq on direct upper", {7'd0, sfrReq}, 8'h01);
    check("R3 sfrAddr", sfrAddr, 8'h90);
    drive(3'd1, 2'd0, 1'b0, 8'h01, 8'h00);
    check("R4 no sfrReq on indirect upper", {7'd0, sfrReq}, 8'h00);
    drive(3'd2, 2'd0, 1'b0, 8'h90, 8'h00);
    check("R6 rdBit sfr", {7'd0, rdBit}, 8'h01);
    drive(3'd2, 2'd0, 1'b0, 8'h15, 8'h00);
    check("R5 rdBit ram set", {7'd0, rdBit}, 8'h01);
    drive(3'd2, 2'd0, 1'b0, 8'h13, 8'h00);
    check("R5 rdBit ram clear", {7'd0, rdBit}, 8'h00);

    for (int k = 0; k < 8; k++) drive(3'd5, 2'd0, 1'b0, 8'h00, 8'h00);
    drive(3'd4, 2'd0, 1'b1, 8'h00, 8'h3C);
    drive(3'd3, 2'd0, 1'b0, 8'h00, 8'h00);
    check("R9 wrap push to 0x00", rdData, 8'h3C);
    drive(3'd5, 2'd0, 1'b0, 8'h00, 8'h00);
    check("R9 pop at 0x00", rdData, 8'h3C);

    doReset();
    drive(3'd0, 2'd0, 1'b0, 8'h22, 8'h00);
    check("R1 ram cleared after reset", rdData, 8'h00);
    drive(3'd4, 2'd0, 1'b1, 8'h00, 8'h11);
    drive(3'd3, 2'd1, 1'b0, 8'h00, 8'h00);
    check("R1 sp reset to 0x07", rdData, 8'h11);
    drive(3'd0, 2'd0, 1'b1, 8'h88, 8'h05);
    check("R10 sfrWrite on write", {7'd0, sfrWrite}, 8'h01);
    drive(3'd0, 2'd0, 1'b0, 8'h88, 8'h00);
    check("R10 no sfrWrite on read", {7'd0, sfrWrite}, 8'h00);
    check("R3 sfr data back", rdData, 8'h05);
    idle();
    check("R10 idle after sfr", {7'd0, sfrReq}, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
    $finish;
  end
endmodule